// File: doc/BRIEF.md
# Reset Controller with Strap Capture

This block merges three reset sources into one internal active-low system reset: a power-on reset, an active-low external reset pin and an active-high watchdog request. Any of them pulls the internal reset low at once, without waiting for a clock edge. Release is aligned to the master clock through a two-stage synchronizer, so the internal reset rises a fixed number of edges after every source has gone quiet.

While the external pin is held low, the block records the configuration straps on every rising clock edge. When the pin returns high, it evaluates the most recent ten samples:

- If the active-low tri-state strap was low on all ten samples, the tri-state mode bit is set.
- The boot-select strap level on the final sample becomes the boot selection.
- If the pin stayed low for fewer than ten edges, both bits keep their earlier values.

The debug-select strap is captured once, right after power-on. An 8-bit cause register reports whether the most recent reset came from the pin or from the watchdog. Downstream logic reads the mode bits and the cause register once the internal reset has been released.

Top module: `rst_strap_ctrl`

## Requirements
- R1: While `ext_rst_n` is low, `sys_rst_n` is low, and it goes low without any clock edge.
- R2: Once `por_n` and `ext_rst_n` are high and `wdog_req` is low, `sys_rst_n` stays low through the first rising clock edge and rises at the second.
- R3: While `wdog_req` is high, `sys_rst_n` is low, and it goes low without any clock edge. Release then follows R2.
- R4: At the first rising edge that sees `ext_rst_n` high after a low period of at least 10 edges, `tri_mode` becomes 1 if `strap_tri_n` was 0 on each of the last 10 edges with the pin low. Otherwise it becomes 0. Samples older than those 10 have no effect.
- R5: At the same edge, `boot_sel` takes the `strap_boot` level seen on the last edge with the pin low, whatever the strap did earlier in the window.
- R6: If the pin was low for fewer than 10 rising edges, `tri_mode` and `boot_sel` keep their previous values.
- R7: `scan_mode` takes the `strap_dbg` level at the first rising edge after `por_n` rises (1 = boundary-scan, 0 = in-circuit debug) and then stays fixed until the next power-on reset.
- R8: `cause` reads 8'h6C after power-on and after a pin reset, and 8'h53 after a watchdog reset. It holds its value through normal operation until the next reset.
- R9: If the pin is low on the same edge as a watchdog request, `cause` records the pin code 8'h6C.
- R10: During power-on reset, `tri_mode` and `boot_sel` are 0 and `sys_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdog_req | input | 1 | Watchdog reset request, active high |
| strap_tri_n | input | 1 | Tri-state strap, active low |
| strap_boot | input | 1 | Boot memory select strap |
| strap_dbg | input | 1 | Debug-select strap (1 = boundary-scan) |
| sys_rst_n | output | 1 | Internal system reset, active low |
| tri_mode | output | 1 | Latched tri-state mode |
| boot_sel | output | 1 | Latched boot memory selection |
| scan_mode | output | 1 | Power-up debug selection |
| cause | output | 8 | Cause of the last reset |

## Verification
The pin reset and the watchdog reset can both hit the cause register in the same clock cycle. The bench provokes this by lowering the pin and raising the watchdog request on the same falling edge. It then expects the pin code 8'h6C, and expects release to follow the pin's timing. Strap evaluation and the first release step also share one edge: the bench checks that the mode bits have changed while `sys_rst_n` is still low, and again one edge later when it rises.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam logic [7:0] CAUSE_PIN  = 8'h6C;
  localparam logic [7:0] CAUSE_WDOG = 8'h53;

  // Pin reset has priority over watchdog when both are seen on one edge.
  function automatic logic [7:0] next_cause(input logic pin_low, input logic wdog,
                                            input logic [7:0] cur);
    if (pin_low)   return CAUSE_PIN;
    else if (wdog) return CAUSE_WDOG;
    else           return cur;
  endfunction
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = q[STAGES-1];
endmodule

// File: rtl/rsc_strap.sv
module rsc_strap #(
  parameter int   WIN      = 10,
  parameter logic BOOT_DEF = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  input  logic strap_tri_n,
  input  logic strap_boot,
  input  logic strap_dbg,
  output logic tri_mode,
  output logic boot_sel,
  output logic scan_mode,
  output logic rel_evt,
  output logic win_full
);
  localparam int CW = $clog2(WIN + 1);

  logic          pin_q;
  logic [CW-1:0] cnt;
  logic [WIN-1:0] hist;
  logic          boot_q;
  logic          dbg_done;

  assign rel_evt  = pin_n & ~pin_q;
  assign win_full = (cnt == CW'(WIN));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pin_q    <= 1'b1;
      cnt      <= '0;
      hist     <= '1;
      boot_q   <= BOOT_DEF;
      tri_mode <= 1'b0;
      boot_sel <= BOOT_DEF;
    end else begin
      pin_q <= pin_n;
      if (!pin_n) begin
        hist   <= {hist[WIN-2:0], strap_tri_n};
        boot_q <= strap_boot;
        if (!win_full) cnt <= cnt + CW'(1);
      end else if (rel_evt) begin
        cnt <= '0;
        if (win_full) begin
          tri_mode <= ~|hist;
          boot_sel <= boot_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dbg_done  <= 1'b0;
      scan_mode <= 1'b0;
    end else if (!dbg_done) begin
      dbg_done  <= 1'b1;
      scan_mode <= strap_dbg;
    end
  end

  a_r6_short_keep: assert property (@(posedge clk) disable iff (!por_n)
    (rel_evt && !win_full) |=> ($stable(tri_mode) && $stable(boot_sel)));

  a_r4_tri_at_release: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(tri_mode) |-> $past(rel_evt));

  a_r7_scan_frozen: assert property (@(posedge clk) disable iff (!por_n)
    dbg_done |=> $stable(scan_mode));
endmodule

// File: rtl/rsc_cause.sv
module rsc_cause (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pin_n,
  input  logic       wdog_req,
  output logic [7:0] cause
);
  import rsc_pkg::*;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause <= CAUSE_PIN;
    else        cause <= next_cause(~pin_n, wdog_req, cause);
  end

  a_r8_wdog_code: assert property (@(posedge clk) disable iff (!por_n)
    (wdog_req && pin_n) |=> (cause == CAUSE_WDOG));

  a_r9_pin_priority: assert property (@(posedge clk) disable iff (!por_n)
    !pin_n |=> (cause == CAUSE_PIN));

  a_r8_cause_legal: assert property (@(posedge clk) disable iff (!por_n)
    (cause == CAUSE_PIN) || (cause == CAUSE_WDOG));
endmodule

// File: rtl/rst_strap_ctrl.sv
module rst_strap_ctrl #(
  parameter int   SYNC_STAGES = 2,
  parameter int   WIN         = 10,
  parameter logic BOOT_DEF    = 1'b0
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic       wdog_req,
  input  logic       strap_tri_n,
  input  logic       strap_boot,
  input  logic       strap_dbg,
  output logic       sys_rst_n,
  output logic       tri_mode,
  output logic       boot_sel,
  output logic       scan_mode,
  output logic [7:0] cause
);
  logic arst_n;
  logic rel_evt;
  logic win_full;

  assign arst_n = por_n & ext_rst_n & ~wdog_req;

  rsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(arst_n), .rst_n_o(sys_rst_n)
  );

  rsc_strap #(.WIN(WIN), .BOOT_DEF(BOOT_DEF)) u_strap (
    .clk(clk), .por_n(por_n), .pin_n(ext_rst_n),
    .strap_tri_n(strap_tri_n), .strap_boot(strap_boot), .strap_dbg(strap_dbg),
    .tri_mode(tri_mode), .boot_sel(boot_sel), .scan_mode(scan_mode),
    .rel_evt(rel_evt), .win_full(win_full)
  );

  rsc_cause u_cause (
    .clk(clk), .por_n(por_n), .pin_n(ext_rst_n), .wdog_req(wdog_req), .cause(cause)
  );

  a_r1_pin_holds: assert property (@(posedge clk) disable iff (!por_n)
    !ext_rst_n |-> !sys_rst_n);

  a_r3_wdog_holds: assert property (@(posedge clk) disable iff (!por_n)
    wdog_req |-> !sys_rst_n);

  a_r2_sync_release: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> $past(arst_n));
endmodule

// File: tb/rst_strap_ctrl_tb_top.sv
module rst_strap_ctrl_tb_top;
  logic clk = 1'b0;
  logic por_n, ext_rst_n, wdog_req, strap_tri_n, strap_boot, strap_dbg;
  logic sys_rst_n, tri_mode, boot_sel, scan_mode;
  logic [7:0] cause;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic exp_tri = 1'b0;
  logic exp_boot = 1'b0;

  always #4 clk = ~clk;

  rst_strap_ctrl dut_i (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdog_req(wdog_req),
    .strap_tri_n(strap_tri_n), .strap_boot(strap_boot), .strap_dbg(strap_dbg),
    .sys_rst_n(sys_rst_n), .tri_mode(tri_mode), .boot_sel(boot_sel),
    .scan_mode(scan_mode), .cause(cause)
  );

  // {edges low, tri strap history, boot strap history}; bit 0 = last edge before release
  localparam logic [39:0] VEC [8] = '{
    {8'd10, 16'h0000, 16'h03FF},
    {8'd12, 16'h0800, 16'h0000},
    {8'd10, 16'h0020, 16'h0001},
    {8'd15, 16'h7FFF, 16'h7FFE},
    {8'd9,  16'h0000, 16'h01FF},
    {8'd11, 16'h0400, 16'h07FF},
    {8'd3,  16'h0007, 16'h0000},
    {8'd10, 16'h0200, 16'h0000}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pin_reset(input int n, input logic [15:0] tseq, input logic [15:0] bseq);
    if (n >= 10) begin
      exp_tri  = (tseq[9:0] == 10'd0);
      exp_boot = bseq[0];
    end
    for (int k = n - 1; k >= 0; k--) begin
      @(negedge clk);
      ext_rst_n   = 1'b0;
      strap_tri_n = tseq[k];
      strap_boot  = bseq[k];
      if (k == n - 1) begin
        #1 check("R1 async pin assert", int'(sys_rst_n), 0);
      end
      @(posedge clk);
    end
    @(negedge clk);
    ext_rst_n = 1'b1;
    @(negedge clk);
    check("R4/R6 tri_mode", int'(tri_mode), int'(exp_tri));
    check("R5/R6 boot_sel", int'(boot_sel), int'(exp_boot));
    check("R2 held one edge", int'(sys_rst_n), 0);
    @(negedge clk);
    check("R2 released second edge", int'(sys_rst_n), 1);
    check("R8 pin cause", int'(cause), 8'h6C);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    por_n = 1'b1; ext_rst_n = 1'b1; wdog_req = 1'b0;
    strap_tri_n = 1'b1; strap_boot = 1'b1; strap_dbg = 1'b1;
    #2 por_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 sys_rst_n in por", int'(sys_rst_n), 0);
    check("R10 tri_mode default", int'(tri_mode), 0);
    check("R10 boot_sel default", int'(boot_sel), 0);
    check("R8 por cause", int'(cause), 8'h6C);
    por_n = 1'b1;
    @(negedge clk);
    check("R7 scan captured", int'(scan_mode), 1);
    check("R2 held after por", int'(sys_rst_n), 0);
    strap_dbg = 1'b0;
    @(negedge clk);
    check("R2 released after por", int'(sys_rst_n), 1);
    repeat (3) @(negedge clk);
    check("R7 scan frozen", int'(scan_mode), 1);

    for (int i = 0; i < 8; i++) begin
      pin_reset(int'(VEC[i][39:32]), VEC[i][31:16], VEC[i][15:0]);
      repeat (2) @(negedge clk);
    end

    // R3 watchdog reset
    @(negedge clk);
    wdog_req = 1'b1;
    #1 check("R3 async wdog assert", int'(sys_rst_n), 0);
    @(negedge clk);
    wdog_req = 1'b0;
    check("R8 wdog cause", int'(cause), 8'h53);
    check("R3 still low", int'(sys_rst_n), 0);
    @(negedge clk);
    check("R3 held one edge", int'(sys_rst_n), 0);
    @(negedge clk);
    check("R3 released", int'(sys_rst_n), 1);
    check("R6 wdog keeps tri", int'(tri_mode), int'(exp_tri));
    repeat (5) @(negedge clk);
    check("R8 cause held", int'(cause), 8'h53);

    // R9 coincidence of pin and watchdog
    ext_rst_n = 1'b0;
    wdog_req  = 1'b1;
    @(negedge clk);
    wdog_req = 1'b0;
    @(negedge clk);
    ext_rst_n = 1'b1;
    check("R9 pin wins", int'(cause), 8'h6C);
    @(negedge clk);
    check("R9 release held", int'(sys_rst_n), 0);
    @(negedge clk);
    check("R9 released", int'(sys_rst_n), 1);

    // second power-on restores defaults
    pin_reset(10, 16'h0000, 16'h0001);
    por_n = 1'b0;
    #1;
    check("R10 tri cleared", int'(tri_mode), 0);
    check("R10 boot cleared", int'(boot_sel), 0);
    check("R10 sys low", int'(sys_rst_n), 0);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check("R7 recapture", int'(scan_mode), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule